// File: doc/BRIEF.md
# Byte-Stepped I2C Bus Master

This block is a single-master I2C controller that software drives one byte at a time through four byte-wide registers on a simple write/read port. Software chooses a transmit or receive mode. It asks for a START by setting the busy bit in the status register, and it asks for a STOP by clearing that bit. After each byte, software steps the transfer forward by writing the control register with its pending bit set. The block drives the bus through open-drain enables, so a high output means the line is pulled low. The bit clock comes from a two-way prescaler followed by a small divider.

When a byte and its acknowledge slot are finished, a sticky pending flag rises and SCL is held low. The bus stays stretched until software releases it, and an interrupt can follow the flag. In transmit mode the acknowledge sampled from the slave is recorded but never stops the transfer. In receive mode, the acknowledge-enable bit decides whether the master answers each received byte with ACK or NAK. A START request issued while the bus is still held produces a repeated START. This lets software chain a sub-address write with a read of the same slave.

Top module: `i2c_byte_master`

## Requirements
- R1: Register addresses are 0 for control, 1 for status, 2 for own-address and 3 for data. After reset, control reads 0x00, status reads 0x10 (serial output enabled), own-address reads 0x00, both bus lines are released and irq is 0.
- R2: Writing status with bit 7 = 1 and bit 5 = 1 (0xF0 selects transmit) from idle makes SDA fall while SCL is high. The data register is then shifted out MSB first, so 0xA0 addresses slave 0x50 for a write (bit 0 = 0).
- R3: The SCL period equals P*(D+1) clock cycles. P is 16 when control bit 6 = 0 and 512 when it is 1, and D is control bits 3:0.
- R4: After the ninth SCL pulse of a byte, control bit 4 (pending) reads 1 and SCL is held low for as long as it stays set. The irq output is 1 exactly when pending and control bit 5 are both 1.
- R5: Writing control with bit 4 = 1 while pending is set clears the flag and starts the next byte. In transmit mode that byte is taken from the data register.
- R6: After every byte, status bit 0 holds the level sampled in the acknowledge slot (0 = ACK). A NAK does not stop the transfer.
- R7: In receive mode (status bits 7:6 = 10), each released byte is sampled MSB first into the data register. The master drives ACK in the acknowledge slot when control bit 7 = 1 and NAK when it is 0.
- R8: A START request made while the bus is still held produces a repeated START (SDA falls while SCL is high) without an intervening STOP. The data register is then sent as the address byte (0xA1 = read of slave 0x50).
- R9: Writing status with bit 5 = 0 while the bus is held, then releasing the pending byte, produces a STOP (SDA rises while SCL is high). Status bit 5 reads 1 until that STOP has finished.
- R10: SDA changes only while SCL is low, except for START, repeated START and STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data, combinational on host_addr |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled level of the SDA line |
| irq | output | 1 | Byte-complete interrupt |

## Verification
The assertions assume that this master is the only master on the bus and that no slave stretches SCL. The block never reads SCL back. They also assume that software writes the status and control registers only while the block is idle or a byte is pending, never while a byte or condition is being shifted. The bench keeps to these assumptions: every command write follows a poll that has seen the pending flag set or the busy bit clear. The behavioural slave changes SDA only just after SCL falls.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [1:0] {
        CMD_START,
        CMD_TX,
        CMD_RX,
        CMD_STOP
    } i2cm_cmd_e;

    typedef enum logic [2:0] {
        E_IDLE,
        E_START,
        E_RSTART,
        E_BIT,
        E_STOP
    } i2cm_eng_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_OWN  = 2'd2;
    localparam logic [1:0] ADDR_DATA = 2'd3;
    localparam logic [1:0] MODE_MRX  = 2'b10;

    typedef struct packed {
        i2cm_eng_e   st;
        logic [1:0]  ph;
        logic [3:0]  bitn;
        logic [7:0]  sh;
        logic        rx;
        logic        ack_send;
        logic        ack_in;
        logic        scl_lo;
        logic        sda_lo;
        logic        held;
        logic        byte_done;
    } i2cm_eng_t;

endpackage

// File: rtl/i2cm_clkgen.sv
module i2cm_clkgen #(
    parameter int PRE_FAST = 16,
    parameter int PRE_SLOW = 512,
    parameter int DIV_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             presel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    // one tick per quarter of an SCL period
    localparam int QF    = PRE_FAST / 4;
    localparam int QS    = PRE_SLOW / 4;
    localparam int CNT_W = $clog2(QS * (1 << DIV_W) + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        lim   = CNT_W'(((presel ? QS : QF) * (int'(div) + 1)) - 1);
        tick  = run && (cnt_q == lim);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      go,
    input  i2cm_cmd_e cmd,
    input  logic [7:0] tx_byte,
    input  logic      ack_gen,
    input  logic      sda_in,
    output logic      active,
    output logic      held,
    output logic      scl_lo,
    output logic      sda_lo,
    output logic      byte_done,
    output logic [7:0] rx_byte,
    output logic      ack_in
);
    i2cm_eng_t r_d, r_q;
    logic last_bit;

    always_comb begin
        r_d           = r_q;
        r_d.byte_done = 1'b0;
        last_bit      = (r_q.bitn == 4'd8);
        if (r_q.st == E_IDLE) begin
            if (go) begin
                r_d.ph   = 2'd0;
                r_d.bitn = 4'd0;
                unique case (cmd)
                    CMD_START: begin
                        r_d.st = r_q.held ? E_RSTART : E_START;
                        r_d.sh = tx_byte;
                        r_d.rx = 1'b0;
                    end
                    CMD_TX: begin
                        r_d.st = E_BIT;
                        r_d.sh = tx_byte;
                        r_d.rx = 1'b0;
                    end
                    CMD_RX: begin
                        r_d.st       = E_BIT;
                        r_d.sh       = 8'h00;
                        r_d.rx       = 1'b1;
                        r_d.ack_send = ack_gen;
                    end
                    CMD_STOP: r_d.st = E_STOP;
                endcase
            end
        end else if (tick) begin
            r_d.ph = r_q.ph + 2'd1;
            unique case (r_q.st)
                E_START: begin
                    // SCL high: pull SDA, then SCL
                    if (r_q.ph == 2'd0) r_d.sda_lo = 1'b1;
                    if (r_q.ph == 2'd2) r_d.scl_lo = 1'b1;
                    if (r_q.ph == 2'd3) begin
                        r_d.st   = E_BIT;
                        r_d.bitn = 4'd0;
                        r_d.held = 1'b1;
                    end
                end
                E_RSTART: begin
                    if (r_q.ph == 2'd0) r_d.sda_lo = 1'b0;
                    if (r_q.ph == 2'd1) r_d.scl_lo = 1'b0;
                    if (r_q.ph == 2'd2) r_d.sda_lo = 1'b1;
                    if (r_q.ph == 2'd3) begin
                        r_d.scl_lo = 1'b1;
                        r_d.st     = E_BIT;
                        r_d.bitn   = 4'd0;
                    end
                end
                E_BIT: begin
                    unique case (r_q.ph)
                        2'd0: begin
                            if (last_bit) r_d.sda_lo = r_q.rx ? r_q.ack_send : 1'b0;
                            else          r_d.sda_lo = r_q.rx ? 1'b0 : !r_q.sh[7];
                        end
                        2'd1: r_d.scl_lo = 1'b0;
                        2'd2: begin
                            if (last_bit) r_d.ack_in = sda_in;
                            else          r_d.sh = {r_q.sh[6:0], sda_in};
                        end
                        2'd3: begin
                            r_d.scl_lo = 1'b1;
                            if (last_bit) begin
                                r_d.st        = E_IDLE;
                                r_d.byte_done = 1'b1;
                            end else begin
                                r_d.bitn = r_q.bitn + 4'd1;
                            end
                        end
                    endcase
                end
                E_STOP: begin
                    if (r_q.ph == 2'd0) r_d.sda_lo = 1'b1;
                    if (r_q.ph == 2'd1) r_d.scl_lo = 1'b0;
                    if (r_q.ph == 2'd2) r_d.sda_lo = 1'b0;
                    if (r_q.ph == 2'd3) begin
                        r_d.st   = E_IDLE;
                        r_d.held = 1'b0;
                    end
                end
                default: r_d.st = E_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: E_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign active    = (r_q.st != E_IDLE);
    assign held      = r_q.held;
    assign scl_lo    = r_q.scl_lo;
    assign sda_lo    = r_q.sda_lo;
    assign byte_done = r_q.byte_done;
    assign rx_byte   = r_q.sh;
    assign ack_in    = r_q.ack_in;

    // R10: with SCL released, SDA moves only inside a start or stop sequence
    a_r10_sda_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.scl_lo && !$past(r_q.scl_lo) && (r_q.sda_lo != $past(r_q.sda_lo)))
        |-> (r_q.st inside {E_START, E_RSTART, E_STOP}));

    // R4: a finished byte leaves SCL pulled low
    a_r4_done_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.byte_done |-> r_q.scl_lo);

    // R2: the bus becomes held only after both lines were pulled by a START
    a_r2_start_lines: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.held) |-> (r_q.sda_lo && r_q.scl_lo));

endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             eng_active,
    input  logic             eng_held,
    input  logic             byte_done,
    input  logic [7:0]       rx_byte,
    input  logic             ack_in,
    output logic             go,
    output i2cm_cmd_e        cmd,
    output logic [7:0]       tx_byte,
    output logic             ack_gen,
    output logic             presel,
    output logic [DIV_W-1:0] div,
    output logic             ser_en,
    output logic             pend,
    output logic             irq
);
    localparam int PAD_W = 4 - DIV_W;

    typedef struct packed {
        logic             ack_en;
        logic             presel;
        logic             irq_en;
        logic             pend;
        logic [DIV_W-1:0] div;
        logic [1:0]       mode;
        logic             ser_en;
        logic             ack_rx;
        logic [7:0]       own;
        logic [7:0]       data;
        logic             req_start;
        logic             req_stop;
        logic             req_byte;
        logic             last_rx;
    } regs_t;

    regs_t r_d, r_q;
    logic  busy;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (addr)
                ADDR_CTRL: begin
                    r_d.ack_en = wdata[7];
                    r_d.presel = wdata[6];
                    r_d.irq_en = wdata[5];
                    r_d.div    = wdata[DIV_W-1:0];
                    if (wdata[4] && r_q.pend) begin
                        r_d.pend     = 1'b0;
                        r_d.req_byte = 1'b1;
                    end
                end
                ADDR_STAT: begin
                    r_d.mode   = wdata[7:6];
                    r_d.ser_en = wdata[4];
                    if (wdata[5] && wdata[7])        r_d.req_start = 1'b1;
                    else if (!wdata[5] && eng_held) r_d.req_stop  = 1'b1;
                end
                ADDR_OWN:  r_d.own  = wdata;
                ADDR_DATA: r_d.data = wdata;
            endcase
        end
        if (byte_done) begin
            r_d.pend   = 1'b1;
            r_d.ack_rx = ack_in;
            if (r_q.last_rx) r_d.data = rx_byte;
        end

        if (r_q.req_stop)       cmd = CMD_STOP;
        else if (r_q.req_start) cmd = CMD_START;
        else if (r_q.mode == MODE_MRX) cmd = CMD_RX;
        else                    cmd = CMD_TX;

        go = !r_q.pend && !eng_active && !byte_done
             && (r_q.req_start || r_q.req_stop || r_q.req_byte);
        if (go) begin
            r_d.req_start = 1'b0;
            r_d.req_stop  = 1'b0;
            r_d.req_byte  = 1'b0;
            r_d.last_rx   = (cmd == CMD_RX);
        end

        busy = eng_held || eng_active || r_q.req_start || r_q.req_stop;
        unique case (addr)
            ADDR_CTRL: rdata = {r_q.ack_en, r_q.presel, r_q.irq_en, r_q.pend,
                                {PAD_W{1'b0}}, r_q.div};
            ADDR_STAT: rdata = {r_q.mode, busy, r_q.ser_en, 3'b000, r_q.ack_rx};
            ADDR_OWN:  rdata = r_q.own;
            default:   rdata = r_q.data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.ser_en <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_byte = r_q.data;
    assign ack_gen = r_q.ack_en;
    assign presel  = r_q.presel;
    assign div     = r_q.div;
    assign ser_en  = r_q.ser_en;
    assign pend    = r_q.pend;
    assign irq     = r_q.pend && r_q.irq_en;

    // R4: a completed byte always raises the pending flag
    a_r4_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> r_q.pend);

    // R4: the bit engine stays idle while software owns the byte
    a_r4_idle_while_pend: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pend |-> !eng_active);

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
    parameter int PRE_FAST = 16,
    parameter int PRE_SLOW = 512,
    parameter int DIV_W    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_we,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_i,
    output logic       irq
);
    import i2cm_pkg::*;

    logic             tick, go, active, held, scl_lo, sda_lo, byte_done;
    logic             ack_in, ack_gen, presel, ser_en, pend;
    logic [7:0]       rx_byte, tx_byte;
    logic [DIV_W-1:0] div;
    i2cm_cmd_e        cmd;

    i2cm_regs #(.DIV_W(DIV_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .we(host_we), .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
        .eng_active(active), .eng_held(held), .byte_done(byte_done),
        .rx_byte(rx_byte), .ack_in(ack_in),
        .go(go), .cmd(cmd), .tx_byte(tx_byte), .ack_gen(ack_gen),
        .presel(presel), .div(div), .ser_en(ser_en), .pend(pend), .irq(irq)
    );

    i2cm_clkgen #(.PRE_FAST(PRE_FAST), .PRE_SLOW(PRE_SLOW), .DIV_W(DIV_W)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .run(active),
        .presel(presel), .div(div), .tick(tick)
    );

    i2cm_engine engine_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .cmd(cmd),
        .tx_byte(tx_byte), .ack_gen(ack_gen), .sda_in(sda_i),
        .active(active), .held(held), .scl_lo(scl_lo), .sda_lo(sda_lo),
        .byte_done(byte_done), .rx_byte(rx_byte), .ack_in(ack_in)
    );

    assign scl_oe = scl_lo && ser_en;
    assign sda_oe = sda_lo && ser_en;

    // R4: the bus is stretched for the whole time a byte is pending
    a_r4_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> scl_lo);

endmodule

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    wire  [7:0] rdata;
    wire        scl_oe, sda_oe, irq;
    logic       s_drv = 1'b0;
    wire        scl_bus = ~scl_oe;
    wire        sda_bus = ~(sda_oe | s_drv);

    always #2 clk = ~clk;

    i2c_byte_master dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(we), .host_addr(addr),
        .host_wdata(wdata), .host_rdata(rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_bus), .irq(irq)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, last_rise = 0, scl_per = 0;
    int n_start = 0, n_stop = 0, exp_start = 0, exp_stop = 0;
    always @(posedge clk) cyc++;
    always @(posedge scl_bus) begin scl_per = cyc - last_rise; last_rise = cyc; end

    // behavioural slave at address 0x50 with a sub-addressed byte memory
    localparam logic [6:0] SLV = 7'h50;
    logic s_on = 0, s_skip = 0, s_first = 0, s_rd = 0, s_ok = 0, s_sub = 0, s_tx = 0, s_mack = 0;
    int   s_pos = 0;
    logic [7:0] s_sh = 0, s_out = 0, s_ptr = 0;
    logic [7:0] smem [256];
    logic [7:0] exp_mem [256];

    always @(negedge sda_bus) if (scl_bus === 1'b1) begin
        n_start++; s_on = 1; s_skip = 1; s_first = 1; s_rd = 0; s_sub = 0;
        s_tx = 0; s_pos = 0; s_drv = 0;
    end
    always @(posedge sda_bus) if (scl_bus === 1'b1) begin
        n_stop++; s_on = 0; s_tx = 0; s_drv = 0;
    end
    always @(posedge scl_bus) if (s_on) begin
        if (s_pos < 8) s_sh = {s_sh[6:0], sda_bus};
        else           s_mack = sda_bus;
    end
    always @(negedge scl_bus) if (s_on) begin
        if (s_skip) s_skip = 0;
        else if (s_pos < 7) begin
            s_pos++;
            if (s_tx) s_drv = !s_out[7 - s_pos];
        end else if (s_pos == 7) begin
            s_pos = 8;
            if (s_tx) s_drv = 0;
            else begin
                if (s_first) begin
                    s_first = 0; s_ok = (s_sh[7:1] == SLV); s_rd = s_sh[0];
                end else if (s_ok) begin
                    if (!s_sub) begin s_ptr = s_sh; s_sub = 1; end
                    else begin smem[s_ptr] = s_sh; s_ptr++; end
                end
                s_drv = s_ok;
            end
        end else begin
            s_pos = 0; s_drv = 0;
            if (s_ok && s_rd && (!s_tx || !s_mack)) begin
                s_tx = 1; s_out = smem[s_ptr]; s_ptr++; s_drv = !s_out[7];
            end else s_tx = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); we = 1; addr = a; wdata = d;
        @(negedge clk); we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; #1; v = rdata;
    endtask

    task automatic wait_pend();
        logic [7:0] v;
        for (int g = 0; g < 60000; g++) begin
            rd(2'd0, v);
            if (v[4]) return;
        end
        chk("R4 pending never set", 0, 1);
    endtask

    task automatic wait_free();
        logic [7:0] v;
        for (int g = 0; g < 60000; g++) begin
            rd(2'd1, v);
            if (!v[5]) return;
        end
        chk("R9 busy never cleared", 1, 0);
    endtask

    // write: address byte, sub-address, two data bytes, STOP
    task automatic do_write(input bit ps, input int dv, input logic [7:0] sub,
                            input logic [7:0] b0, input logic [7:0] b1);
        logic [7:0] v, cw;
        logic [7:0] seq [3];
        cw = {1'b1, ps, 1'b1, 1'b1, 4'(dv)};
        seq[0] = sub; seq[1] = b0; seq[2] = b1;
        wr(2'd0, cw);
        wr(2'd3, 8'hA0);
        wr(2'd1, 8'hF0); exp_start++;
        wait_pend();
        chk("R2 START count", n_start, exp_start);
        chk("R3 SCL period", scl_per, (ps ? 512 : 16) * (dv + 1));
        rd(2'd1, v);
        chk("R6 address ACK bit", int'(v[0]), 0);
        chk("R4 irq with pending", int'(irq), 1);
        repeat (40) @(negedge clk);
        chk("R4 SCL stretched", int'(scl_bus), 0);
        for (int k = 0; k < 3; k++) begin
            wr(2'd3, seq[k]);
            wr(2'd0, cw);
            wait_pend();
            rd(2'd1, v);
            chk("R5 data byte ACK", int'(v[0]), 0);
        end
        exp_mem[sub] = b0; exp_mem[8'(sub + 1)] = b1;
        wr(2'd1, 8'hD0);
        wr(2'd0, cw);
        rd(2'd1, v);
        chk("R9 busy during STOP", int'(v[5]), 1);
        wait_free(); exp_stop++;
        chk("R9 STOP count", n_stop, exp_stop);
        chk("R10 START edges", n_start, exp_start);
        chk("R5 stored b0", int'(smem[sub]), int'(b0));
        chk("R5 stored b1", int'(smem[8'(sub + 1)]), int'(b1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 256; i++) begin smem[i] = 8'h00; exp_mem[i] = 8'h00; end
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        n_start = 0; n_stop = 0;

        // R1 reset state
        rd(2'd0, v); chk("R1 control reset", v, 8'h00);
        rd(2'd1, v); chk("R1 status reset", v, 8'h10);
        rd(2'd2, v); chk("R1 own-address reset", v, 8'h00);
        chk("R1 SCL released", int'(scl_bus), 1);
        chk("R1 SDA released", int'(sda_bus), 1);
        chk("R1 irq low", int'(irq), 0);
        wr(2'd2, 8'h5C); rd(2'd2, v); chk("R1 own-address write", v, 8'h5C);

        // divider sweep at the fast prescaler, then the slow prescaler
        for (int dv = 0; dv < 4; dv++)
            do_write(1'b0, dv, 8'(2 * dv), 8'(8'h3C ^ (dv * 17)), 8'(8'hC3 + dv * 29));
        do_write(1'b1, 0, 8'h08, 8'h96, 8'h69);

        // R8/R7: sub-address write, repeated START, three-byte read
        wr(2'd0, 8'hA0);
        wr(2'd3, 8'hA0);
        wr(2'd1, 8'hF0); exp_start++;
        wait_pend();
        wr(2'd3, 8'h02);
        wr(2'd0, 8'hB0);
        wait_pend();
        wr(2'd3, 8'hA1);
        wr(2'd1, 8'hB0);
        wr(2'd0, 8'hB0); exp_start++;
        wait_pend();
        chk("R8 repeated START count", n_start, exp_start);
        chk("R8 no STOP before read", n_stop, exp_stop);
        rd(2'd1, v); chk("R8 read address ACK", int'(v[0]), 0);
        for (int k = 0; k < 3; k++) begin
            wr(2'd0, (k == 2) ? 8'h30 : 8'hB0);
            wait_pend();
            rd(2'd3, v);
            chk("R7 received byte", v, exp_mem[8'(2 + k)]);
            chk("R7 master ACK/NAK level", int'(s_mack), (k == 2) ? 1 : 0);
        end
        wr(2'd1, 8'h90);
        wr(2'd0, 8'hB0);
        wait_free(); exp_stop++;
        chk("R9 STOP after read", n_stop, exp_stop);
        chk("R10 START edges after read", n_start, exp_start);

        // R6: unanswered address, transfer continues; R4: irq masked
        wr(2'd0, 8'h90);
        wr(2'd3, 8'hB4);
        wr(2'd1, 8'hF0); exp_start++;
        wait_pend();
        rd(2'd1, v); chk("R6 NAK recorded", int'(v[0]), 1);
        chk("R4 irq masked", int'(irq), 0);
        wr(2'd3, 8'h11);
        wr(2'd0, 8'h90);
        wait_pend();
        rd(2'd1, v); chk("R6 continues after NAK", int'(v[0]), 1);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'h90);
        wait_free(); exp_stop++;
        chk("R9 STOP after NAK", n_stop, exp_stop);
        chk("R10 total START edges", n_start, exp_start);
        chk("R6 memory untouched", int'(smem[8'h11]), 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule